// File: doc/BRIEF.md
# Dual-Bank Mode Router and Address Decoder

This block sits behind two serial slave front ends and in front of two 256-byte storage arrays. Each front end hands it the device address byte it received, a stop indication, and per-byte read and write strobes carrying a word address. The block decides whether to acknowledge the address byte, steers each accepted strobe to the right array, blocks writes while the write-protect input is high, and runs a write-cycle timer per array. The mode pin selects how the two ports relate to the two arrays.

With the mode pin high (bank mode), port 1 owns array 1 and port 2 owns array 2. The two ports run at the same time without affecting each other. With the mode pin low (combined mode), port 2 is dead. Port 1 sees one 512-byte space, and bit 1 of the device address byte acts as the ninth address bit. The byte layout of the arrays is the same in both modes, so data written in one mode reads back unchanged in the other.

Each port runs a session state machine with three states. SES_IDLE has no session open. SES_WRITE is an acknowledged write session, and SES_READ is an acknowledged read session. The transitions are:

- idle to write or read: an accepted address byte, chosen by its R/W bit.
- write or read to idle: a stop, or a rejected address byte.
- write or read to write or read: an accepted repeated address byte.

Each array timer is a down-counter: zero means ready, and any other value means busy. The active mode is sampled from the pin only while the whole block is idle.

Top module: `dual_bank_router`

## Requirements
- R1: In bank mode, a device address byte acknowledges on port k only when bits [7:4] are 1010 and bits [3:1] are 000. Bit 0 is R/W, with 1 meaning read. The acknowledge is a one-cycle pulse in the cycle after the address strobe.
- R2: In combined mode, port 2 never acknowledges and never enables either array. Port 1 ignores address bits [3:2].
- R3: In combined mode, address bit 1 selects the array (0 for array 1, 1 for array 2), and the port's word address goes unchanged to that array. Data written in one mode reads back unchanged in the other mode.
- R4: While wp is high, no array write enable is asserted and no write cycle starts. Address bytes are still acknowledged and reads still return data.
- R5: A stop, or a repeated address byte, that ends a write session holding at least one accepted write makes the target array busy for exactly WRITE_CYCLES cycles, starting the next cycle. A write session with no accepted write starts no cycle.
- R6: An address byte that targets a busy array is not acknowledged, and the busy array receives no write. The other array stays available.
- R7: In bank mode, both ports may open sessions, write and stop in the same cycles, each reaching only its own array.
- R8: A change on mode_bank takes effect only when both ports are idle, no array is busy and no address strobe is present. It is visible on cur_bank_mode in the cycle after such an idle cycle.
- R9: A write strobe outside a write session, or a read strobe outside a read session, enables no array.
- R10: After reset there is no acknowledge, no busy flag and no array enable, and cur_bank_mode is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_bank | input | 1 | 1 selects bank mode, 0 selects combined mode |
| wp | input | 1 | Write protect for both arrays |
| p1_addr_valid | input | 1 | Port 1 device address byte strobe |
| p1_addr_byte | input | 8 | Port 1 device address byte |
| p1_stop | input | 1 | Port 1 stop seen |
| p1_wr | input | 1 | Port 1 data byte write strobe |
| p1_rd | input | 1 | Port 1 data byte read strobe |
| p1_word | input | WORD_W | Port 1 word address |
| p1_wdata | input | DATA_W | Port 1 write data |
| p1_ack | output | 1 | Port 1 address acknowledge pulse |
| p1_rdata | output | DATA_W | Port 1 read data |
| p2_addr_valid | input | 1 | Port 2 device address byte strobe |
| p2_addr_byte | input | 8 | Port 2 device address byte |
| p2_stop | input | 1 | Port 2 stop seen |
| p2_wr | input | 1 | Port 2 data byte write strobe |
| p2_rd | input | 1 | Port 2 data byte read strobe |
| p2_word | input | WORD_W | Port 2 word address |
| p2_wdata | input | DATA_W | Port 2 write data |
| p2_ack | output | 1 | Port 2 address acknowledge pulse |
| p2_rdata | output | DATA_W | Port 2 read data |
| a1_en | output | 1 | Array 1 access enable |
| a1_we | output | 1 | Array 1 write enable |
| a1_addr | output | WORD_W | Array 1 address |
| a1_wdata | output | DATA_W | Array 1 write data |
| a1_rdata | input | DATA_W | Array 1 read data (combinational) |
| a1_busy | output | 1 | Array 1 write cycle in progress |
| a2_en | output | 1 | Array 2 access enable |
| a2_we | output | 1 | Array 2 write enable |
| a2_addr | output | WORD_W | Array 2 address |
| a2_wdata | output | DATA_W | Array 2 write data |
| a2_rdata | input | DATA_W | Array 2 read data (combinational) |
| a2_busy | output | 1 | Array 2 write cycle in progress |
| cur_bank_mode | output | 1 | Mode currently in force |

## Verification
The assertions assume three things about the front ends:

- A stop and an address strobe never arrive on the same port in the same cycle.
- Each strobe is a single-cycle pulse.
- Address strobes are held low during reset.

The stimulus keeps to these rules because it drives every strobe through tasks that raise it for exactly one cycle and issue stops separately. Random transactions wait out every write cycle before the next session, so the expected acknowledge can be computed from the mode, the port and the address byte alone. Busy-time refusals and simultaneous bank-mode traffic are covered by directed sequences.

// File: rtl/drb_pkg.sv
package drb_pkg;

    typedef enum logic [1:0] {
        SES_IDLE  = 2'd0,
        SES_WRITE = 2'd1,
        SES_READ  = 2'd2
    } ses_state_t;

    localparam logic [3:0] DEV_CODE   = 4'b1010;
    localparam int         NUM_ARRAYS = 2;

endpackage

// File: rtl/drb_addr_decode.sv
module drb_addr_decode
    import drb_pkg::*;
#(
    parameter int PORT_SEL = 0
) (
    input  logic [7:0] dev_byte,
    input  logic       combined,
    output logic       hit,
    output logic       target,
    output logic       is_read
);

    localparam logic PORT_BIT = (PORT_SEL != 0);

    always_comb begin
        is_read = dev_byte[0];
        if (combined) begin
            // port 2 is dead; bits [3:2] are don't-care, bit 1 is address bit 8
            hit    = (dev_byte[7:4] == DEV_CODE) && !PORT_BIT;
            target = dev_byte[1];
        end else begin
            hit    = (dev_byte[7:4] == DEV_CODE) && (dev_byte[3:1] == 3'b000);
            target = PORT_BIT;
        end
    end

endmodule

// File: rtl/drb_port_fsm.sv
module drb_port_fsm
    import drb_pkg::*;
#(
    parameter int PORT_SEL = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  combined,
    input  logic                  wp,
    input  logic [NUM_ARRAYS-1:0] busy_vec,
    input  logic                  addr_valid,
    input  logic [7:0]            addr_byte,
    input  logic                  stop,
    input  logic                  wr,
    input  logic                  rd,
    output logic                  ack,
    output logic                  active,
    output logic                  tgt,
    output logic                  wr_fire,
    output logic                  rd_fire,
    output logic                  cyc_start
);

    ses_state_t state_q, state_d;
    logic       tgt_q;
    logic       dirty_q;
    logic       ack_q;
    logic       dec_hit, dec_tgt, dec_rd;
    logic       busy_eff;
    logic       accept;

    drb_addr_decode #(.PORT_SEL(PORT_SEL)) u_dec (
        .dev_byte (addr_byte),
        .combined (combined),
        .hit      (dec_hit),
        .target   (dec_tgt),
        .is_read  (dec_rd)
    );

    // a write session that closes now launches its cycle; count it as busy already
    always_comb begin
        cyc_start = (state_q == SES_WRITE) && dirty_q && (stop || addr_valid);
        busy_eff  = busy_vec[dec_tgt] || (cyc_start && (dec_tgt == tgt_q));
        accept    = addr_valid && !stop && dec_hit && !busy_eff;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SES_IDLE: begin
                if (accept)
                    state_d = dec_rd ? SES_READ : SES_WRITE;
            end
            SES_WRITE, SES_READ: begin
                if (stop)
                    state_d = SES_IDLE;
                else if (addr_valid)
                    state_d = accept ? (dec_rd ? SES_READ : SES_WRITE) : SES_IDLE;
            end
            default: state_d = SES_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SES_IDLE;
            tgt_q   <= 1'b0;
            dirty_q <= 1'b0;
            ack_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ack_q   <= accept;
            if (accept)
                tgt_q <= dec_tgt;
            if (accept || stop || addr_valid)
                dirty_q <= 1'b0;
            else if (wr_fire)
                dirty_q <= 1'b1;
        end
    end

    always_comb begin
        ack     = ack_q;
        active  = (state_q != SES_IDLE);
        tgt     = tgt_q;
        wr_fire = wr && (state_q == SES_WRITE) && !wp;
        rd_fire = rd && (state_q == SES_READ);
    end

endmodule

// File: rtl/drb_wr_timer.sv
module drb_wr_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= LOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/dual_bank_router.sv
module dual_bank_router
    import drb_pkg::*;
#(
    parameter int WORD_W       = 8,
    parameter int DATA_W       = 8,
    parameter int WRITE_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_bank,
    input  logic              wp,
    input  logic              p1_addr_valid,
    input  logic [7:0]        p1_addr_byte,
    input  logic              p1_stop,
    input  logic              p1_wr,
    input  logic              p1_rd,
    input  logic [WORD_W-1:0] p1_word,
    input  logic [DATA_W-1:0] p1_wdata,
    output logic              p1_ack,
    output logic [DATA_W-1:0] p1_rdata,
    input  logic              p2_addr_valid,
    input  logic [7:0]        p2_addr_byte,
    input  logic              p2_stop,
    input  logic              p2_wr,
    input  logic              p2_rd,
    input  logic [WORD_W-1:0] p2_word,
    input  logic [DATA_W-1:0] p2_wdata,
    output logic              p2_ack,
    output logic [DATA_W-1:0] p2_rdata,
    output logic              a1_en,
    output logic              a1_we,
    output logic [WORD_W-1:0] a1_addr,
    output logic [DATA_W-1:0] a1_wdata,
    input  logic [DATA_W-1:0] a1_rdata,
    output logic              a1_busy,
    output logic              a2_en,
    output logic              a2_we,
    output logic [WORD_W-1:0] a2_addr,
    output logic [DATA_W-1:0] a2_wdata,
    input  logic [DATA_W-1:0] a2_rdata,
    output logic              a2_busy,
    output logic              cur_bank_mode
);

    localparam int NP = NUM_ARRAYS;

    logic              mode_q;
    logic              combined;
    logic [NP-1:0]     av_v, stop_v, wr_v, rd_v;
    logic [7:0]        ab_v [NP];
    logic [NP-1:0]     ack_v, act_v, tgt_v, wrf_v, rdf_v, cyc_v;
    logic [NP-1:0]     start_v, busy_v;
    logic              idle_all;
    logic              own2;

    assign combined = !mode_q;

    always_comb begin
        av_v   = {p2_addr_valid, p1_addr_valid};
        stop_v = {p2_stop, p1_stop};
        wr_v   = {p2_wr, p1_wr};
        rd_v   = {p2_rd, p1_rd};
        ab_v[0] = p1_addr_byte;
        ab_v[1] = p2_addr_byte;
    end

    for (genvar g = 0; g < NP; g++) begin : g_port
        drb_port_fsm #(.PORT_SEL(g)) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .combined   (combined),
            .wp         (wp),
            .busy_vec   (busy_v),
            .addr_valid (av_v[g]),
            .addr_byte  (ab_v[g]),
            .stop       (stop_v[g]),
            .wr         (wr_v[g]),
            .rd         (rd_v[g]),
            .ack        (ack_v[g]),
            .active     (act_v[g]),
            .tgt        (tgt_v[g]),
            .wr_fire    (wrf_v[g]),
            .rd_fire    (rdf_v[g]),
            .cyc_start  (cyc_v[g])
        );
    end

    // port 1 reaches either array; port 2 only ever targets array 2
    always_comb begin
        start_v[0] = cyc_v[0] && (tgt_v[0] == 1'b0);
        start_v[1] = (cyc_v[0] && (tgt_v[0] == 1'b1)) || cyc_v[1];
    end

    for (genvar a = 0; a < NP; a++) begin : g_timer
        drb_wr_timer #(.CYCLES(WRITE_CYCLES)) u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .start (start_v[a]),
            .busy  (busy_v[a])
        );
    end

    // mode sampling: only when the whole block is quiet
    assign idle_all = (act_v == '0) && (busy_v == '0) && (av_v == '0);

    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= 1'b1;
        else if (idle_all)
            mode_q <= mode_bank;
    end

    // array routing
    assign own2 = combined ? 1'b0 : 1'b1;

    always_comb begin
        a1_addr  = p1_word;
        a1_wdata = p1_wdata;
        a1_we    = wrf_v[0] && (tgt_v[0] == 1'b0);
        a1_en    = (wrf_v[0] || rdf_v[0]) && (tgt_v[0] == 1'b0);

        if (own2) begin
            a2_addr  = p2_word;
            a2_wdata = p2_wdata;
            a2_we    = wrf_v[1];
            a2_en    = wrf_v[1] || rdf_v[1];
        end else begin
            a2_addr  = p1_word;
            a2_wdata = p1_wdata;
            a2_we    = wrf_v[0] && (tgt_v[0] == 1'b1);
            a2_en    = (wrf_v[0] || rdf_v[0]) && (tgt_v[0] == 1'b1);
        end

        p1_rdata = tgt_v[0] ? a2_rdata : a1_rdata;
        p2_rdata = a2_rdata;
    end

    assign p1_ack        = ack_v[0];
    assign p2_ack        = ack_v[1];
    assign a1_busy       = busy_v[0];
    assign a2_busy       = busy_v[1];
    assign cur_bank_mode = mode_q;

endmodule

// File: rtl/drb_checker.sv
module drb_checker (
    input logic clk,
    input logic rst_n,
    input logic wp,
    input logic p1_addr_valid,
    input logic p1_stop,
    input logic p1_ack,
    input logic p2_addr_valid,
    input logic p2_stop,
    input logic p2_ack,
    input logic a1_en,
    input logic a1_we,
    input logic a1_busy,
    input logic a2_en,
    input logic a2_we,
    input logic a2_busy,
    input logic cur_bank_mode
);

    AST_ACK_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        p1_ack |-> $past(p1_addr_valid)); // R1

    AST_P2_SILENT_COMBINED: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_bank_mode |-> !p2_ack); // R2

    AST_WP_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wp |-> !(a1_en && a1_we) && !(a2_en && a2_we)); // R4

    AST_BUSY1_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a1_busy) |-> $past(p1_stop || p1_addr_valid)); // R5

    AST_BUSY2_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a2_busy) |-> $past(p1_stop || p1_addr_valid || p2_stop || p2_addr_valid)); // R5

    AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (a1_busy |-> !(a1_en && a1_we)) and (a2_busy |-> !(a2_en && a2_we))); // R6

    AST_MODE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (a1_busy || a2_busy) |=> $stable(cur_bank_mode)); // R8

endmodule

bind dual_bank_router drb_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wp            (wp),
    .p1_addr_valid (p1_addr_valid),
    .p1_stop       (p1_stop),
    .p1_ack        (p1_ack),
    .p2_addr_valid (p2_addr_valid),
    .p2_stop       (p2_stop),
    .p2_ack        (p2_ack),
    .a1_en         (a1_en),
    .a1_we         (a1_we),
    .a1_busy       (a1_busy),
    .a2_en         (a2_en),
    .a2_we         (a2_we),
    .a2_busy       (a2_busy),
    .cur_bank_mode (cur_bank_mode)
);

// File: tb/dual_bank_router_tb.sv
module dual_bank_router_tb;

    localparam int WORD_W = 8;
    localparam int DATA_W = 8;
    localparam int WC     = 16;
    localparam int DEPTH  = 1 << WORD_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_bank = 1'b1, wp = 1'b0;
    logic p1_av = 0, p1_stop = 0, p1_wr = 0, p1_rd = 0;
    logic p2_av = 0, p2_stop = 0, p2_wr = 0, p2_rd = 0;
    logic [7:0] p1_ab = 0, p2_ab = 0;
    logic [WORD_W-1:0] p1_word = 0, p2_word = 0;
    logic [DATA_W-1:0] p1_wdata = 0, p2_wdata = 0;
    logic p1_ack, p2_ack;
    logic [DATA_W-1:0] p1_rdata, p2_rdata;
    logic a1_en, a1_we, a1_busy, a2_en, a2_we, a2_busy, cur_bank_mode;
    logic [WORD_W-1:0] a1_addr, a2_addr;
    logic [DATA_W-1:0] a1_wdata, a2_wdata, a1_rdata, a2_rdata;

    logic [DATA_W-1:0] mem1 [DEPTH];
    logic [DATA_W-1:0] mem2 [DEPTH];
    logic [DATA_W-1:0] sh1 [DEPTH];
    logic [DATA_W-1:0] sh2 [DEPTH];

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    dual_bank_router #(.WORD_W(WORD_W), .DATA_W(DATA_W), .WRITE_CYCLES(WC)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_bank(mode_bank), .wp(wp),
        .p1_addr_valid(p1_av), .p1_addr_byte(p1_ab), .p1_stop(p1_stop),
        .p1_wr(p1_wr), .p1_rd(p1_rd), .p1_word(p1_word), .p1_wdata(p1_wdata),
        .p1_ack(p1_ack), .p1_rdata(p1_rdata),
        .p2_addr_valid(p2_av), .p2_addr_byte(p2_ab), .p2_stop(p2_stop),
        .p2_wr(p2_wr), .p2_rd(p2_rd), .p2_word(p2_word), .p2_wdata(p2_wdata),
        .p2_ack(p2_ack), .p2_rdata(p2_rdata),
        .a1_en(a1_en), .a1_we(a1_we), .a1_addr(a1_addr), .a1_wdata(a1_wdata),
        .a1_rdata(a1_rdata), .a1_busy(a1_busy),
        .a2_en(a2_en), .a2_we(a2_we), .a2_addr(a2_addr), .a2_wdata(a2_wdata),
        .a2_rdata(a2_rdata), .a2_busy(a2_busy),
        .cur_bank_mode(cur_bank_mode)
    );

    // storage array models
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem1[i] <= '0;
                mem2[i] <= '0;
            end
        end else begin
            if (a1_en && a1_we) mem1[a1_addr] <= a1_wdata;
            if (a2_en && a2_we) mem2[a2_addr] <= a2_wdata;
        end
    end
    assign a1_rdata = mem1[a1_addr];
    assign a2_rdata = mem2[a2_addr];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_ack(input logic bank, input int p, input logic [7:0] b);
        if (b[7:4] != 4'hA) return 1'b0;
        if (bank) return (b[3:1] == 3'b000);
        return (p == 1);
    endfunction

    function automatic int exp_arr(input logic bank, input int p, input logic [7:0] b);
        return bank ? p : (b[1] ? 2 : 1);
    endfunction

    task automatic do_addr(input int p, input logic [7:0] b, output logic ack);
        @(negedge clk);
        if (p == 1) begin p1_av = 1; p1_ab = b; end
        else        begin p2_av = 1; p2_ab = b; end
        @(negedge clk);
        p1_av = 0; p2_av = 0;
        ack = (p == 1) ? p1_ack : p2_ack;
    endtask

    task automatic do_wr(input int p, input logic [7:0] w, input logic [7:0] d,
                         output logic [1:0] we_seen);
        @(negedge clk);
        if (p == 1) begin p1_wr = 1; p1_word = w; p1_wdata = d; end
        else        begin p2_wr = 1; p2_word = w; p2_wdata = d; end
        #1;
        we_seen = {a2_en && a2_we, a1_en && a1_we};
        @(negedge clk);
        p1_wr = 0; p2_wr = 0;
    endtask

    task automatic do_rd(input int p, input logic [7:0] w, output logic [7:0] d);
        @(negedge clk);
        if (p == 1) begin p1_rd = 1; p1_word = w; end
        else        begin p2_rd = 1; p2_word = w; end
        #1;
        d = (p == 1) ? p1_rdata : p2_rdata;
        @(negedge clk);
        p1_rd = 0; p2_rd = 0;
    endtask

    task automatic do_stop(input int p);
        @(negedge clk);
        if (p == 1) p1_stop = 1; else p2_stop = 1;
        @(negedge clk);
        p1_stop = 0; p2_stop = 0;
    endtask

    task automatic wait_idle();
        repeat (WC + 3) @(negedge clk);
    endtask

    task automatic set_mode(input logic m);
        mode_bank = m;
        repeat (3) @(negedge clk);
    endtask

    task automatic sh_write(input int arr, input logic [7:0] w, input logic [7:0] d);
        if (arr == 1) sh1[w] = d; else sh2[w] = d;
    endtask

    function automatic logic [7:0] sh_read(input int arr, input logic [7:0] w);
        return (arr == 1) ? sh1[w] : sh2[w];
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic ack, ack2;
        logic [1:0] we;
        logic [7:0] d;
        logic bank;
        int p, arr, nb;
        logic [7:0] b, w, dv;

        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < DEPTH; i++) begin sh1[i] = 0; sh2[i] = 0; end

        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R10 reset state
        chk("R10 ack", {p1_ack, p2_ack}, 0);
        chk("R10 busy", {a1_busy, a2_busy}, 0);
        chk("R10 en", {a1_en, a2_en}, 0);
        chk("R10 mode", cur_bank_mode, 1);

        // R1 bank decode
        do_addr(1, 8'hA0, ack); chk("R1 p1 A0", ack, 1); do_stop(1);
        do_addr(1, 8'hA2, ack); chk("R1 p1 sel001", ack, 0);
        do_addr(1, 8'hB0, ack); chk("R1 p1 code", ack, 0);
        do_addr(2, 8'hA1, ack); chk("R1 p2 A1", ack, 1); do_stop(2);
        do_addr(2, 8'hA8, ack); chk("R1 p2 sel100", ack, 0);
        @(negedge clk); chk("R1 pulse", {p1_ack, p2_ack}, 0);

        // R5 busy duration
        do_addr(1, 8'hA0, ack);
        do_wr(1, 8'h05, 8'h77, we); chk("R5 we", we, 2'b01); sh_write(1, 8'h05, 8'h77);
        do_stop(1);
        chk("R5 busy start", a1_busy, 1);
        repeat (WC - 1) @(negedge clk);
        chk("R5 busy last", a1_busy, 1);
        @(negedge clk);
        chk("R5 busy end", a1_busy, 0);
        // R5 no write, no cycle
        do_addr(1, 8'hA0, ack); do_stop(1);
        chk("R5 empty session", a1_busy, 0);

        // R6 refuse while busy
        do_addr(1, 8'hA0, ack);
        do_wr(1, 8'h06, 8'h66, we); sh_write(1, 8'h06, 8'h66);
        do_stop(1);
        do_addr(1, 8'hA0, ack); chk("R6 nak busy", ack, 0);
        do_addr(2, 8'hA0, ack); chk("R6 other free", ack, 1); do_stop(2);
        wait_idle();
        do_addr(1, 8'hA0, ack); chk("R6 ack after", ack, 1); do_stop(1);

        // R7 simultaneous bank-mode writes
        @(negedge clk); p1_av = 1; p1_ab = 8'hA0; p2_av = 1; p2_ab = 8'hA0;
        @(negedge clk); p1_av = 0; p2_av = 0;
        chk("R7 both ack", {p1_ack, p2_ack}, 2'b11);
        @(negedge clk);
        p1_wr = 1; p1_word = 8'h33; p1_wdata = 8'h11;
        p2_wr = 1; p2_word = 8'h33; p2_wdata = 8'h22;
        #1;
        chk("R7 both we", {a2_we, a1_we, a2_wdata, a1_wdata}, {2'b11, 8'h22, 8'h11});
        @(negedge clk); p1_wr = 0; p2_wr = 0;
        sh_write(1, 8'h33, 8'h11); sh_write(2, 8'h33, 8'h22);
        @(negedge clk); p1_stop = 1; p2_stop = 1;
        @(negedge clk); p1_stop = 0; p2_stop = 0;
        chk("R7 both busy", {a2_busy, a1_busy}, 2'b11);
        wait_idle();
        do_addr(1, 8'hA1, ack); do_rd(1, 8'h33, d); chk("R7 p1 read", d, 8'h11); do_stop(1);
        do_addr(2, 8'hA1, ack); do_rd(2, 8'h33, d); chk("R7 p2 read", d, 8'h22); do_stop(2);

        // R2 / R3 combined mode
        set_mode(0);
        chk("R8 mode idle", cur_bank_mode, 0);
        do_addr(1, 8'hA2, ack); chk("R3 comb a8=1 ack", ack, 1);
        do_wr(1, 8'h10, 8'h5A, we); chk("R3 a8=1 to array2", we, 2'b10); sh_write(2, 8'h10, 8'h5A);
        do_stop(1); wait_idle();
        do_addr(1, 8'hAC, ack); chk("R2 upper bits ignored", ack, 1);
        do_wr(1, 8'h10, 8'hC3, we); chk("R3 a8=0 to array1", we, 2'b01); sh_write(1, 8'h10, 8'hC3);
        do_stop(1); wait_idle();
        do_addr(2, 8'hA0, ack); chk("R2 p2 no ack", ack, 0);
        do_wr(2, 8'h10, 8'hEE, we); chk("R2 p2 no array", we, 2'b00);
        do_rd(2, 8'h10, d); chk("R2 p2 no en", {a1_en, a2_en}, 0);
        set_mode(1);
        do_addr(2, 8'hA1, ack); do_rd(2, 8'h10, d); chk("R3 bank read array2", d, 8'h5A); do_stop(2);
        do_addr(1, 8'hA1, ack); do_rd(1, 8'h10, d); chk("R3 bank read array1", d, 8'hC3); do_stop(1);
        do_addr(2, 8'hA0, ack); do_wr(2, 8'h20, 8'h99, we); sh_write(2, 8'h20, 8'h99);
        do_stop(2); wait_idle();
        set_mode(0);
        do_addr(1, 8'hA3, ack); do_rd(1, 8'h20, d); chk("R3 comb read bank-written", d, 8'h99); do_stop(1);
        set_mode(1);

        // R4 write protect
        wp = 1;
        do_addr(1, 8'hA0, ack); chk("R4 ack under wp", ack, 1);
        do_wr(1, 8'h05, 8'h00, we); chk("R4 no we", we, 2'b00);
        do_stop(1); chk("R4 no cycle", a1_busy, 0);
        do_addr(1, 8'hA1, ack); do_rd(1, 8'h05, d); chk("R4 read ok", d, 8'h77); do_stop(1);
        wp = 0;

        // R9 strobes outside matching session
        do_addr(1, 8'hA1, ack);
        do_wr(1, 8'h05, 8'h01, we); chk("R9 wr in read session", we, 2'b00);
        do_stop(1);
        do_addr(1, 8'hA4, ack); chk("R9 nak", ack, 0);
        do_wr(1, 8'h05, 8'h02, we); chk("R9 wr after nak", we, 2'b00);
        do_addr(2, 8'hA0, ack);
        do_rd(2, 8'h05, d); chk("R9 rd in write session", {a1_en, a2_en}, 0);
        do_stop(2);

        // R8 mode held while a session is open
        do_addr(1, 8'hA0, ack);
        mode_bank = 0;
        repeat (4) @(negedge clk);
        chk("R8 held in session", cur_bank_mode, 1);
        do_stop(1);
        chk("R8 held at stop", cur_bank_mode, 1);
        @(negedge clk);
        chk("R8 applied when idle", cur_bank_mode, 0);
        set_mode(1);

        // random mix
        for (int it = 0; it < 80; it++) begin
            bank = 1'($urandom % 2);
            if (bank != cur_bank_mode) set_mode(bank);
            wp = ($urandom % 4 == 0);
            p = 1 + ($urandom % 2);
            if ($urandom % 4 == 0) b = 8'($urandom);
            else b = {4'hA, 3'($urandom % 8) & (($urandom % 2) ? 3'b111 : 3'b000), 1'($urandom % 2)};
            do_addr(p, b, ack);
            chk("R1 R2 random ack", ack, exp_ack(bank, p, b));
            arr = exp_arr(bank, p, b);
            if (ack && !b[0]) begin
                nb = 1 + ($urandom % 3);
                for (int k = 0; k < nb; k++) begin
                    w = 8'($urandom); dv = 8'($urandom);
                    do_wr(p, w, dv, we);
                    chk("R3 R4 random we", we, wp ? 2'b00 : ((arr == 1) ? 2'b01 : 2'b10));
                    if (!wp) sh_write(arr, w, dv);
                end
            end else if (ack) begin
                for (int k = 0; k < 2; k++) begin
                    w = 8'($urandom);
                    do_rd(p, w, d);
                    chk("R3 random read", d, sh_read(arr, w));
                end
            end
            do_stop(p);
            ack2 = (p == 1) ? p1_ack : p2_ack;
            chk("R1 no stray ack", ack2, 0);
            wait_idle();
        end
        wp = 0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule